// File: doc/BRIEF.md
# Multi-CPU Interrupt Mask Router

This block routes interrupts to four processors. A shared 64-bit request register follows the device interrupt lines one cycle at a time. Each processor has its own 64-bit mask. A processor's device-interrupt line is high whenever its mask and the captured requests overlap. A register port lets software program the masks and read back three things: the raw requests, each processor's masked pending set, and each processor's interval-ignore counter.

A shared tick drives the interval timers. Each present processor has a 25-bit counter that is decremented on every tick. Once the counter has gone below zero, its top bit stays set, and from then on every tick raises that processor's timer interrupt. Timer interrupts are recorded as flags in a status register and are cleared by writing ones to them. A read of the status register returns the stored flags and revision code, with the reading processor's index placed in the two lowest bits. A presence parameter marks processors that are not fitted. Their timer lines and counters stay idle.

Top module: `irq_mask_router`

## Requirements
- R1: After reset every mask and every counter is zero, the request register is zero, all device and timer lines are low, and the status register holds 0x8_0000_0000.
- R2: The request register captures `dev_irq` on every clock edge and is read raw at address 0x1.
- R3: `dev_int[i]` is high exactly when mask i AND the request register is nonzero. It reflects a mask write, or a change on `dev_irq`, in the cycle right after the edge that captures it.
- R4: Address 0x8+i reads mask i ANDed with the request register.
- R5: Address 0x4+i writes and reads mask i. Each mask is independent of the others.
- R6: A write to address 0xC+i stores only the low 24 bits of the data into counter i and clears its bit 24. A read of 0xC+i returns the 25-bit counter zero-extended.
- R7: On each `tick`, a present processor's counter becomes ((v-1) mod 2^25) with bit 24 ORed back in from v. A counter write in the same cycle wins over the tick.
- R8: When a counter's new value has bit 24 set on a tick, status bit 4+i and `tmr_int[i]` go high on the next cycle and stay high.
- R9: A read of address 0x0 returns the stored status with `rd_cpu` in bits 1:0.
- R10: Writing 1 to status bit 4+i clears that flag and lowers `tmr_int[i]`. Writing zeros has no effect. A tick that fires in the same cycle as the clear keeps the flag set.
- R11: For a processor whose `PRESENT` bit is 0, the timer line and its status flag stay 0, and its counter is not decremented by ticks.
- R12: Writes to the request address, the pending views, and the status bits outside the flag bits leave the read-back state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | REG_W | Device interrupt request lines |
| tick | input | 1 | Interval-timer tick, one-cycle pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | REG_W | Write data |
| rd_cpu | input | 2 | Index of the processor issuing the access |
| rdata | output | REG_W | Read data, valid the cycle after `rd_en` |
| dev_int | output | NCPU | Per-processor device-interrupt lines |
| tmr_int | output | NCPU | Per-processor timer-interrupt lines |

## Verification
The bench sweeps sixteen mask and request combinations across all four processors. It includes masks that only partly overlap the requests, so a design that tested one word lane, or that evaluated the line before the new mask was in place, would report a wrong line or a wrong pending view. The timer test starts counters at 0, 1 and 3 and runs ticks past their underflow. A design that let bit 24 be cleared by the decrement, or that fired before the underflow, would drop or add timer interrupts. The bench also checks a flag clear that lands together with a firing tick, a clear made of zero bits, and an absent processor. A design that let the clear win, or that ticked the absent counter, would show up in the status or counter reads.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W = 4;
  localparam int CPU_W  = 2;
  // address groups selected by addr[3:2]; index in addr[1:0]
  localparam logic [1:0] GRP_CTL  = 2'd0;
  localparam logic [1:0] GRP_MASK = 2'd1;
  localparam logic [1:0] GRP_PEND = 2'd2;
  localparam logic [1:0] GRP_CNT  = 2'd3;
  localparam logic [1:0] IDX_STAT = 2'd0;
  localparam logic [1:0] IDX_REQ  = 2'd1;
  localparam int FLAG_LSB = 4;
endpackage

// File: rtl/irq_iic_ctr.sv
module irq_iic_ctr #(
  parameter int CNT_W = 24,
  parameter bit EN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic [CNT_W:0]   cnt,
  output logic             fire
);
  logic [CNT_W:0] dec;
  logic [CNT_W:0] nxt;

  assign dec  = cnt - 1'b1;
  assign nxt  = {dec[CNT_W] | cnt[CNT_W], dec[CNT_W-1:0]};
  assign fire = EN && tick && !wr && nxt[CNT_W];

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (wr)          cnt <= {1'b0, wdata};
    else if (tick && EN)  cnt <= nxt;
  end

  // R6
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> cnt == {1'b0, $past(wdata)});
  // R7
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (EN && tick && !wr && !cnt[CNT_W] && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R7
  top_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt[CNT_W] && !wr) |=> cnt[CNT_W]);
  // R11
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!EN && !wr) |=> $stable(cnt));
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] req_nxt,
  input  logic [REG_W-1:0] req_cur,
  output logic [REG_W-1:0] mask,
  output logic             dev_int
);
  logic [REG_W-1:0] mask_nxt;

  assign mask_nxt = mask_wr ? wdata : mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= '0;
      dev_int <= 1'b0;
    end else begin
      mask    <= mask_nxt;
      dev_int <= |(mask_nxt & req_nxt);
    end
  end

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> mask == $past(wdata));
  // R3
  line_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> dev_int == |(mask & req_cur));
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int               NCPU    = 4,
  parameter int               REG_W   = 64,
  parameter int               CNT_W   = 24,
  parameter logic [NCPU-1:0]  PRESENT = '1,
  parameter logic [REG_W-1:0] REV     = 64'h8_0000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_W-1:0]     dev_irq,
  input  logic                 tick,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [CPU_W-1:0]     rd_cpu,
  output logic [REG_W-1:0]     rdata,
  output logic [NCPU-1:0]      dev_int,
  output logic [NCPU-1:0]      tmr_int
);
  localparam int CW1 = CNT_W + 1;

  logic [REG_W-1:0] req_q;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] mask_a [NCPU];
  logic [CW1-1:0]   cnt_a  [NCPU];
  logic [NCPU-1:0]  fire;
  logic [1:0]       grp;
  logic [1:0]       idx;
  logic             stat_wr;
  logic [REG_W-1:0] rd_mux;

  assign grp     = addr[3:2];
  assign idx     = addr[1:0];
  assign stat_wr = wr_en && grp == GRP_CTL && idx == IDX_STAT;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= dev_irq;
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    irq_cpu_slice #(.REG_W(REG_W)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .mask_wr (wr_en && grp == GRP_MASK && idx == i[1:0]),
      .wdata   (wdata),
      .req_nxt (dev_irq),
      .req_cur (req_q),
      .mask    (mask_a[i]),
      .dev_int (dev_int[i])
    );
    irq_iic_ctr #(.CNT_W(CNT_W), .EN(PRESENT[i])) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .wr    (wr_en && grp == GRP_CNT && idx == i[1:0]),
      .wdata (wdata[CNT_W-1:0]),
      .tick  (tick),
      .cnt   (cnt_a[i]),
      .fire  (fire[i])
    );
    assign tmr_int[i] = stat_q[FLAG_LSB+i];

    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(tmr_int[i]) |-> $past(tick));
    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_wr && wdata[FLAG_LSB+i] && !fire[i]) |=> !tmr_int[i]);
    if (!PRESENT[i]) begin : g_absent
      // R11
      absent_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_int[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= REV;
    end else begin
      for (int i = 0; i < NCPU; i++) begin
        if (fire[i])
          stat_q[FLAG_LSB+i] <= 1'b1;
        else if (stat_wr && wdata[FLAG_LSB+i])
          stat_q[FLAG_LSB+i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (grp == GRP_CTL) begin
      if (idx == IDX_STAT)     rd_mux = stat_q | REG_W'(rd_cpu);
      else if (idx == IDX_REQ) rd_mux = req_q;
    end else begin
      for (int i = 0; i < NCPU; i++) begin
        if (idx == i[1:0]) begin
          case (grp)
            GRP_MASK: rd_mux = mask_a[i];
            GRP_PEND: rd_mux = mask_a[i] & req_q;
            GRP_CNT:  rd_mux = REG_W'(cnt_a[i]);
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R1
  rev_keep_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[REG_W-1:FLAG_LSB+NCPU] == REV[REG_W-1:FLAG_LSB+NCPU]);
endmodule

// File: tb/irq_mask_router_bench.sv
module irq_mask_router_bench;
  localparam logic [3:0]  PRES = 4'b0111;
  localparam logic [63:0] REVV = 64'h8_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] dev_irq = '0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [1:0]  rd_cpu = '0;
  logic [63:0] rdata;
  logic [3:0]  dev_int;
  logic [3:0]  tmr_int;

  int total = 0;
  int bad = 0;

  logic [63:0] m_mask [4];
  logic [24:0] m_cnt  [4];
  logic [63:0] m_req;
  logic [63:0] m_stat;

  always #10ns clk = ~clk;

  irq_mask_router #(.PRESENT(PRES)) u_irq_mask_router (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rd_cpu(rd_cpu),
    .rdata(rdata), .dev_int(dev_int), .tmr_int(tmr_int)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] c, output logic [63:0] d);
    addr = a; rd_cpu = c; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [3:0] exp_dev();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = (m_mask[i] & m_req) != 64'd0;
    return e;
  endfunction

  function automatic logic [24:0] step(input logic [24:0] v);
    return ((v - 25'd1) & 25'h1FF_FFFF) | (v & 25'h100_0000);
  endfunction

  function automatic logic [3:0] exp_tmr();
    return m_stat[7:4];
  endfunction

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (PRES[i]) begin
        m_cnt[i] = step(m_cnt[i]);
        if (m_cnt[i][24]) m_stat[4+i] = 1'b1;
      end
    end
  endtask

  initial begin
    #(20ns * 150000);
    bad++;
    $display("FAIL watchdog: act=%h exp=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    for (int i = 0; i < 4; i++) begin m_mask[i] = '0; m_cnt[i] = '0; end
    m_req = '0;
    m_stat = REVV;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 dev_int", {60'd0, dev_int}, 64'd0);
    chk("R1 tmr_int", {60'd0, tmr_int}, 64'd0);
    for (int i = 0; i < 4; i++) begin
      rd(4'h4 + 4'(i), 2'd0, d); chk("R1 mask", d, 64'd0);
      rd(4'hC + 4'(i), 2'd0, d); chk("R1 counter", d, 64'd0);
    end
    rd(4'h1, 2'd0, d); chk("R1 request", d, 64'd0);

    // R9 status per reader
    for (int c = 0; c < 4; c++) begin
      rd(4'h0, 2'(c), d); chk("R9 status reader", d, REVV | 64'(c));
    end

    // R2 R3 R4 R5 sweep
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 4; i++) begin
        m_mask[i] = (64'd1 << ((k * 7 + i * 13) % 64)) |
                    ((k % 2 == 1) ? (64'hF0 << (i * 16)) : 64'd0);
        wr(4'h4 + 4'(i), m_mask[i]);
        chk("R3 line after mask write", {60'd0, dev_int}, {60'd0, exp_dev()});
      end
      m_req = (64'd1 << ((k * 11) % 64)) |
              (((k / 2) % 2 == 1) ? 64'h00F0_0000_0000_00F0 : 64'd0) |
              (((k / 4) % 2 == 1) ? (64'hF << (k * 3)) : 64'd0);
      dev_irq = m_req;
      @(negedge clk);
      chk("R3 line after request change", {60'd0, dev_int}, {60'd0, exp_dev()});
      rd(4'h1, 2'd1, d); chk("R2 raw request", d, m_req);
      for (int i = 0; i < 4; i++) begin
        rd(4'h8 + 4'(i), 2'd0, d); chk("R4 pending view", d, m_mask[i] & m_req);
        rd(4'h4 + 4'(i), 2'd0, d); chk("R5 mask readback", d, m_mask[i]);
      end
    end

    // R12 writes to read-only places
    wr(4'h1, 64'hDEAD_BEEF_0000_1111);
    wr(4'h9, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(4'h0, 64'hFFFF_FFFF_FFFF_FF0F);
    rd(4'h1, 2'd0, d); chk("R12 request untouched", d, m_req);
    rd(4'h9, 2'd0, d); chk("R12 pending untouched", d, m_mask[1] & m_req);
    rd(4'h0, 2'd3, d); chk("R12 status untouched", d, REVV | 64'd3);
    chk("R12 lines untouched", {60'd0, dev_int}, {60'd0, exp_dev()});

    // R6 counter write truncation
    wr(4'hC, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'hC, 2'd0, d); chk("R6 low 24 bits kept", d, 64'h00FF_FFFF);

    // timer phase
    m_cnt[0] = 25'd0; wr(4'hC, 64'hAB00_0000);
    m_cnt[1] = 25'd3; wr(4'hD, 64'd3);
    m_cnt[2] = 25'd1; wr(4'hE, 64'd1);
    m_cnt[3] = 25'd0; wr(4'hF, 64'd0);
    for (int i = 0; i < 4; i++) begin
      rd(4'hC + 4'(i), 2'd0, d); chk("R6 counter load", d, 64'(m_cnt[i]));
    end
    for (int t = 0; t < 6; t++) begin
      do_tick();
      chk("R8 timer lines", {60'd0, tmr_int}, {60'd0, exp_tmr()});
      chk("R11 absent line low", {63'd0, tmr_int[3]}, 64'd0);
      for (int i = 0; i < 4; i++) begin
        rd(4'hC + 4'(i), 2'd0, d); chk("R7 counter step", d, 64'(m_cnt[i]));
      end
      rd(4'h0, 2'd1, d); chk("R8 status flags", d, m_stat | 64'd1);
    end

    // R10 clear one flag, junk elsewhere ignored
    wr(4'h0, 64'hFFFF_0000_0000_0013);
    m_stat[4] = 1'b0;
    chk("R10 clear flag", {60'd0, tmr_int}, {60'd0, exp_tmr()});
    rd(4'h0, 2'd2, d); chk("R10 status after clear", d, m_stat | 64'd2);
    wr(4'h0, 64'd0);
    chk("R10 zero write no effect", {60'd0, tmr_int}, {60'd0, exp_tmr()});

    // R10 clear together with firing tick: tick wins
    addr = 4'h0; wdata = 64'h20; wr_en = 1'b1;
    do_tick();
    wr_en = 1'b0;
    chk("R10 tick wins over clear", {63'd0, tmr_int[1]}, 64'd1);
    chk("R10 lines after combined", {60'd0, tmr_int}, {60'd0, exp_tmr()});
    rd(4'hF, 2'd0, d); chk("R11 absent counter idle", d, 64'd0);

    // R7 write wins over tick
    addr = 4'hE; wdata = 64'd5; wr_en = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    m_cnt[2] = 25'd5;
    m_cnt[0] = step(m_cnt[0]); m_cnt[1] = step(m_cnt[1]);
    rd(4'hE, 2'd0, d); chk("R7 write beats tick", d, 64'd5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule